// File: doc/BRIEF.md
# I2C serial EEPROM slave controller

This block is the bus-facing controller of a 16-Kbit serial EEPROM that answers as a slave on a two-wire I2C bus. It oversamples the bus lines on the system clock, recognises START and STOP conditions, and checks the device address byte. It then runs the write, current-address read, random read and sequential read transactions. It pulls SDA low through an open-drain enable, never driving it high.

Incoming write data is handed to an external page buffer as address/data load strobes. A STOP after at least one accepted data byte raises a commit strobe, which starts an internal write cycle of a fixed number of system clocks. For the length of that cycle the controller leaves its own address unacknowledged, so a master can poll for completion. Read data is fetched from the array through a combinational address/data pair. A write-protect input, captured at one specific SCL edge, refuses the data phase of a write.

Top module: `seeprom_i2c_slave`

## Requirements
- R1: After reset SDA is released (`sda_pull` = 0), `wr_busy` = 0 and no strobe is active.
- R2: A START (SDA falling while SCL is high) opens a transaction, and a START in any state restarts address-byte reception. Bytes clocked without a preceding START get no acknowledge.
- R3: The device address byte is bit 7..4 = `1010`, bit 3..1 = memory address bits 10..8, bit 0 = direction (1 read, 0 write). A byte with any other top nibble is NoACKed, and the slave stays silent until the next START.
- R4: Bits are taken on SCL rising edges, MSB first. The slave's acknowledge (SDA low) and its output data bits change only while SCL is low, on the ninth and first to eighth clocks of a byte respectively.
- R5: A write is header (direction 0), one low address byte, then data bytes, each acknowledged. Every accepted data byte is loaded to the page buffer, and a STOP then commits it and holds `wr_busy` high for `WR_CYCLES` clocks.
- R6: During a write the address advances only in its low 4 bits (16-byte page), wrapping inside the page.
- R7: While `wr_busy` is high, a device address byte gets no acknowledge; once it falls, the same byte is acknowledged.
- R8: Write protect is captured on the SCL falling edge that ends the low-address acknowledge. If it is high there, every data byte is NoACKed and nothing is committed; a later rise of write protect has no effect on that write.
- R9: A read header returns the byte at the current address pointer, and the pointer advances by one after every byte sent.
- R10: A master ACK after a read byte makes the slave send the next byte, wrapping from the last address 0x7FF to 0x000. A master NoACK makes it release SDA and wait for a new START.
- R11: Header (direction 0), low address byte, repeated START, then a read header returns data from the loaded address and writes nothing.
- R12: A repeated START after accepted data bytes abandons the write: no commit, the array unchanged.
- R13: A STOP before any data byte only sets the pointer: no commit and `wr_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| wp_in | input | 1 | Write-protect request, high blocks writes |
| sda_pull | output | 1 | Open-drain enable, 1 pulls SDA low |
| rd_addr | output | 11 | Array read address (current pointer) |
| rd_data | input | 8 | Array read data for `rd_addr` |
| pb_clear | output | 1 | Pulse: empty the page buffer for a new write |
| pb_load | output | 1 | Pulse: store `pb_data` at `pb_addr` in the page buffer |
| pb_addr | output | 11 | Full byte address of the loaded byte |
| pb_data | output | 8 | Data byte being loaded |
| pb_commit | output | 1 | Pulse: program the page buffer into the array |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
The bench keeps the default geometry of an 11-bit address and a 16-byte page, so block bits in the header, page wrap and the wrap from 0x7FF to 0x000 are all reached with real addresses. It shortens `WR_CYCLES` to 600 clocks. At that length a header sent right after a STOP still lands inside the write cycle, and completion polling finishes after a few attempts. SCL runs at 32 system clocks per bit, so the synchronizer delay sits well inside each SCL phase.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    // Transaction phase of the slave.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_ADR,
        PH_DAT,
        PH_RD
    } phase_e;

    // Bus events after synchronization.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    localparam logic [3:0] DEV_ID_DEFAULT = 4'b1010;

    function automatic logic dev_hit(input logic [7:0] b, input logic [3:0] id);
        return b[7:4] == id;
    endfunction

endpackage

// File: rtl/seeprom_busmon.sv
module seeprom_busmon
    import seeprom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_in};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[DEPTH-2];
    assign scl_old = scl_pipe[DEPTH-1];
    assign sda_now = sda_pipe[DEPTH-2];
    assign sda_old = sda_pipe[DEPTH-1];

    always_comb begin
        ev.start = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop  = scl_now & scl_old & ~sda_old & sda_now;
        ev.rise  = scl_now & ~scl_old;
        ev.fall  = ~scl_now & scl_old;
        ev.scl   = scl_now;
        ev.sda   = sda_now;
    end

endmodule

// File: rtl/seeprom_wrtimer.sv
module seeprom_wrtimer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/seeprom_i2c_slave.sv
module seeprom_i2c_slave
    import seeprom_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         PAGE_W      = 4,
    parameter logic [3:0] DEV_ID      = DEV_ID_DEFAULT,
    parameter int         WR_CYCLES   = 50000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              wp_in,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              pb_clear,
    output logic              pb_load,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [7:0]        pb_data,
    output logic              pb_commit,
    output logic              wr_busy
);
    // Block bits carried in the header: device byte bits BLK_W..1.
    localparam int BLK_W = ADDR_W - 8;
    localparam logic [PAGE_W-1:0] PG_ONE  = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    bus_ev_t ev;

    seeprom_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    seeprom_wrtimer #(.CYCLES(WR_CYCLES)) u_wrtimer (
        .clk  (clk),
        .rst  (rst),
        .kick (pb_commit),
        .busy (wr_busy)
    );

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] p);
        return {p[ADDR_W-1:PAGE_W], p[PAGE_W-1:0] + PG_ONE};
    endfunction

    phase_e            ph;
    logic [3:0]        bcnt;
    logic              ack_ph;
    logic              ack_go;
    logic              rw;
    logic              wp_lat;
    logic              written;
    logic              mack;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rx_byte;
    logic              receiving;

    assign rx_byte   = {shreg[6:0], ev.sda};
    assign receiving = (ph == PH_DEV) || (ph == PH_ADR) || (ph == PH_DAT);
    assign rd_addr   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            bcnt      <= '0;
            ack_ph    <= 1'b0;
            ack_go    <= 1'b0;
            rw        <= 1'b0;
            wp_lat    <= 1'b0;
            written   <= 1'b0;
            mack      <= 1'b0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            sda_pull  <= 1'b0;
            pb_clear  <= 1'b0;
            pb_load   <= 1'b0;
            pb_addr   <= '0;
            pb_data   <= '0;
            pb_commit <= 1'b0;
        end else begin
            pb_clear  <= 1'b0;
            pb_load   <= 1'b0;
            pb_commit <= 1'b0;
            if (ev.start) begin
                ph       <= PH_DEV;
                bcnt     <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
                written  <= 1'b0;
            end else if (ev.stop) begin
                if (ph == PH_DAT && written) begin
                    pb_commit <= 1'b1;
                end
                ph       <= PH_IDLE;
                bcnt     <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
                written  <= 1'b0;
            end else if (receiving) begin
                if (ev.rise && bcnt < 4'd8) begin
                    shreg <= rx_byte;
                    bcnt  <= bcnt + 4'd1;
                    if (bcnt == 4'd7) begin
                        unique case (ph)
                            PH_DEV: begin
                                ack_go <= dev_hit(rx_byte, DEV_ID) && !wr_busy;
                                rw     <= rx_byte[0];
                                if (dev_hit(rx_byte, DEV_ID) && !wr_busy) begin
                                    ptr[ADDR_W-1:8] <= rx_byte[BLK_W:1];
                                end
                            end
                            PH_ADR: begin
                                ack_go    <= 1'b1;
                                ptr[7:0]  <= rx_byte;
                            end
                            default: begin
                                ack_go <= !wp_lat;
                                if (!wp_lat) begin
                                    pb_load <= 1'b1;
                                    pb_addr <= ptr;
                                    pb_data <= rx_byte;
                                    ptr     <= page_step(ptr);
                                    written <= 1'b1;
                                end
                            end
                        endcase
                    end
                end else if (ev.fall && bcnt == 4'd8 && !ack_ph) begin
                    ack_ph   <= 1'b1;
                    sda_pull <= ack_go;
                end else if (ev.fall && ack_ph) begin
                    ack_ph   <= 1'b0;
                    sda_pull <= 1'b0;
                    bcnt     <= '0;
                    if (ph == PH_DEV) begin
                        if (!ack_go) begin
                            ph <= PH_IDLE;
                        end else if (rw) begin
                            ph       <= PH_RD;
                            sda_pull <= ~rd_data[7];
                            txreg    <= {rd_data[6:0], 1'b0};
                            bcnt     <= 4'd1;
                        end else begin
                            ph <= PH_ADR;
                        end
                    end else if (ph == PH_ADR) begin
                        ph       <= PH_DAT;
                        wp_lat   <= wp_in;
                        pb_clear <= 1'b1;
                    end
                end
            end else if (ph == PH_RD) begin
                if (ev.fall && !ack_ph) begin
                    if (bcnt == 4'd8) begin
                        ack_ph   <= 1'b1;
                        sda_pull <= 1'b0;
                    end else begin
                        sda_pull <= ~txreg[7];
                        txreg    <= {txreg[6:0], 1'b0};
                        bcnt     <= bcnt + 4'd1;
                    end
                end else if (ev.rise && ack_ph) begin
                    mack <= ~ev.sda;
                    ptr  <= ptr + PTR_ONE;
                end else if (ev.fall && ack_ph) begin
                    ack_ph <= 1'b0;
                    if (mack) begin
                        sda_pull <= ~rd_data[7];
                        txreg    <= {rd_data[6:0], 1'b0};
                        bcnt     <= 4'd1;
                    end else begin
                        ph   <= PH_IDLE;
                        bcnt <= '0;
                    end
                end
            end
        end
    end

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_busy && ph == PH_DEV) |-> !sda_pull);

    // R8
    wp_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DAT && wp_lat) |-> !sda_pull);

    // R5
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        pb_commit |-> $past(ev.stop));

    // R5
    busy_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        pb_commit |=> wr_busy);

    // R4
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

endmodule

// File: tb/seeprom_i2c_slave_bench.sv
module seeprom_i2c_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WR_CYC     = 600;
    localparam int NTBL       = 6;
    localparam logic [3:0] DEV = 4'b1010;

    // {address[10:0], data[7:0]}
    localparam logic [18:0] TBL [NTBL] = '{
        {11'h000, 8'h5A}, {11'h37F, 8'hA5}, {11'h7FF, 8'h01},
        {11'h43B, 8'hD2}, {11'h181, 8'h96}, {11'h642, 8'hE7}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_line;

    logic        sda_pull, pb_clear, pb_load, pb_commit, wr_busy;
    logic [10:0] rd_addr, pb_addr;
    logic [7:0]  rd_data, pb_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    seeprom_i2c_slave #(.WR_CYCLES(WR_CYC)) u_seeprom_i2c_slave (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .wp_in(wp),
        .sda_pull(sda_pull), .rd_addr(rd_addr), .rd_data(rd_data),
        .pb_clear(pb_clear), .pb_load(pb_load), .pb_addr(pb_addr),
        .pb_data(pb_data), .pb_commit(pb_commit), .wr_busy(wr_busy)
    );

    // Array and page buffer model driven only by the block's ports.
    logic [7:0]  mem  [2048];
    logic [7:0]  pend [16];
    logic [15:0] pval;
    logic [6:0]  ppage;

    assign rd_data = mem[rd_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'hFF;
            pval <= '0;
            ppage <= '0;
        end else if (pb_clear) begin
            pval <= '0;
        end else if (pb_load) begin
            pend[pb_addr[3:0]] <= pb_data;
            pval[pb_addr[3:0]] <= 1'b1;
            ppage <= pb_addr[10:4];
        end else if (pb_commit) begin
            for (int i = 0; i < 16; i++)
                if (pval[i]) mem[{ppage, i[3:0]}] <= pend[i];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); sda_m = 1'b0; tq(); scl_m = 1'b0; tq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); sda_m = 1'b1; tq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tq(); scl_m = 1'b1; tq(); tq(); scl_m = 1'b0; tq();
        end
        sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); acked = !sda_line; tq(); scl_m = 1'b0; tq();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tq(); scl_m = 1'b1; tq(); b[i] = sda_line; tq(); scl_m = 1'b0;
        end
        tq(); sda_m = !give_ack; tq(); scl_m = 1'b1; tq(); tq(); scl_m = 1'b0; tq();
        sda_m = 1'b1;
    endtask

    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    logic       hdr_ack, adr_ack;
    logic [3:0] dat_ack;

    task automatic write_seq(input logic [10:0] a, input int n);
        logic k;
        bus_start();
        put_byte({DEV, a[10:8], 1'b0}, k); hdr_ack = k;
        put_byte(a[7:0], k); adr_ack = k;
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], k); dat_ack[i] = k;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [10:0] a, input int n);
        logic k;
        logic [7:0] v;
        bus_start();
        put_byte({DEV, a[10:8], 1'b0}, k);
        put_byte(a[7:0], k);
        bus_start();
        put_byte({DEV, a[10:8], 1'b1}, k);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v); rbuf[i] = v;
        end
        bus_stop();
    endtask

    task automatic cur_read(input logic [2:0] blk, output logic [7:0] v);
        logic k;
        bus_start();
        put_byte({DEV, blk, 1'b1}, k);
        get_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic wait_ready(output logic ok);
        logic k;
        ok = 1'b0;
        for (int i = 0; i < 40 && !ok; i++) begin
            bus_start(); put_byte({DEV, 3'd0, 1'b0}, k); bus_stop();
            ok = k;
        end
    endtask

    initial begin
        logic k, ok;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 sda released", {31'd0, sda_pull}, 32'd0);
        chk("R1 not busy", {31'd0, wr_busy}, 32'd0);
        chk("R1 no strobes", {29'd0, pb_clear, pb_load, pb_commit}, 32'd0);

        // Table walk: byte write then random read back (R4 R5 R11)
        for (int t = 0; t < NTBL; t++) begin
            wbuf[0] = TBL[t][7:0];
            write_seq(TBL[t][18:8], 1);
            chk("R4 acks on write", {29'd0, hdr_ack, adr_ack, dat_ack[0]}, 32'd7);
            wait_ready(ok);
            chk("R7 poll completes", {31'd0, ok}, 32'd1);
            read_seq(TBL[t][18:8], 1);
            chk("R11 random read data", {24'd0, rbuf[0]}, {24'd0, TBL[t][7:0]});
        end

        // R2: byte with no START is ignored
        bus_start(); bus_stop();
        put_byte({DEV, 3'd0, 1'b0}, k);
        chk("R2 no START no ACK", {31'd0, k}, 32'd0);
        bus_stop();

        // R3: wrong device nibble, then silence until START
        bus_start();
        put_byte(8'hB0, k);
        chk("R3 foreign id NoACK", {31'd0, k}, 32'd0);
        put_byte({DEV, 3'd0, 1'b0}, k);
        chk("R3 silent until START", {31'd0, k}, 32'd0);
        bus_stop();

        // R5 two-byte write, R7 busy NoACK
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        write_seq(11'h150, 2);
        chk("R5 two data acks", {30'd0, dat_ack[1:0]}, 32'd3);
        chk("R5 busy after STOP", {31'd0, wr_busy}, 32'd1);
        bus_start(); put_byte({DEV, 3'd1, 1'b0}, k); bus_stop();
        chk("R7 NoACK while busy", {31'd0, k}, 32'd0);
        wait_ready(ok);
        chk("R7 ACK after cycle", {31'd0, ok}, 32'd1);
        read_seq(11'h150, 1);
        chk("R5 first byte stored", {24'd0, rbuf[0]}, 32'hC1);
        cur_read(3'd1, v);
        chk("R9 current read next", {24'd0, v}, 32'hC2);
        cur_read(3'd1, v);
        chk("R9 pointer advances", {24'd0, v}, 32'hFF);

        // R6 page wrap: 0x20E,0x20F,0x200,0x201
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        write_seq(11'h20E, 4);
        wait_ready(ok);
        read_seq(11'h200, 3);
        chk("R6 wrapped byte 0", {24'd0, rbuf[0]}, 32'h33);
        chk("R6 wrapped byte 1", {24'd0, rbuf[1]}, 32'h44);
        chk("R6 untouched 0x202", {24'd0, rbuf[2]}, 32'hFF);
        read_seq(11'h20E, 3);
        chk("R6 page tail 0x20E", {24'd0, rbuf[0]}, 32'h11);
        chk("R6 page tail 0x20F", {24'd0, rbuf[1]}, 32'h22);
        chk("R10 next page not spilled", {24'd0, rbuf[2]}, 32'hFF);

        // R10 sequential read wraps end of memory
        read_seq(11'h7FF, 2);
        chk("R10 last address", {24'd0, rbuf[0]}, 32'h01);
        chk("R10 wrap to 0x000", {24'd0, rbuf[1]}, 32'h5A);

        // R8 write protect high at capture edge
        wp = 1'b1;
        wbuf[0] = 8'h77;
        write_seq(11'h630, 1);
        wp = 1'b0;
        chk("R8 header/addr ACK, data NoACK", {29'd0, hdr_ack, adr_ack, dat_ack[0]}, 32'd6);
        chk("R8 no write cycle", {31'd0, wr_busy}, 32'd0);
        read_seq(11'h630, 1);
        chk("R8 array unchanged", {24'd0, rbuf[0]}, 32'hFF);

        // R8 protect raised after capture edge has no effect
        bus_start();
        put_byte({DEV, 3'd6, 1'b0}, k);
        put_byte(8'h31, k);
        wp = 1'b1;
        put_byte(8'h6D, k);
        chk("R8 late protect ignored", {31'd0, k}, 32'd1);
        bus_stop();
        wp = 1'b0;
        wait_ready(ok);
        read_seq(11'h631, 1);
        chk("R8 late protect data stored", {24'd0, rbuf[0]}, 32'h6D);

        // R12 repeated START abandons write
        bus_start();
        put_byte({DEV, 3'd7, 1'b0}, k);
        put_byte(8'h20, k);
        put_byte(8'h99, k);
        bus_start();
        put_byte({DEV, 3'd7, 1'b1}, k);
        chk("R2 repeated START restarts header", {31'd0, k}, 32'd1);
        get_byte(1'b0, v);
        bus_stop();
        chk("R12 no write cycle", {31'd0, wr_busy}, 32'd0);
        read_seq(11'h720, 1);
        chk("R12 array unchanged", {24'd0, rbuf[0]}, 32'hFF);

        // R13 address only, then current read
        bus_start();
        put_byte({DEV, 3'd4, 1'b0}, k);
        put_byte(8'h3B, k);
        bus_stop();
        chk("R13 no write cycle", {31'd0, wr_busy}, 32'd0);
        cur_read(3'd4, v);
        chk("R13 pointer loaded", {24'd0, v}, 32'hD2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule